// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers event pulses from three on-chip sources (two timers and a shift register) into a 7-bit flag register. A 7-bit enable register selects which pending flags may raise the single level-sensitive interrupt line. Software reaches both registers through a byte-wide port. A one-bit selector picks the register. Writes and reads complete in a single cycle.

Software clears a flag by writing a 1 to its bit position in the flag register. The enable register is written through a selector in bit 7. With bit 7 high, the ones in bits 6:0 turn the matching enables on. With bit 7 low, the ones in bits 6:0 turn the matching enables off. Bit 7 is never stored in either register. On a read, bit 7 of the flag register reports whether any enabled flag is pending, and bit 7 of the enable register always reads as 1.

Top module: `irq_flag_enable_unit`

## Requirements
- R1: `irq_o` is a registered output. In the cycle after the AND of flags and enables becomes nonzero, it reads 1. In the cycle after that AND becomes zero, it reads 0.
- R2: When `sel_i`=0 the flag register is selected. `rdata_o[6:0]` shows the stored flags. `rdata_o[7]` is 1 exactly when some flag bit and its enable bit are both 1 in the current state.
- R3: When `sel_i`=1 the enable register is selected. `rdata_o[7]` is always 1 and `rdata_o[6:0]` shows the stored enables.
- R4: An enable write (`wr_en_i`=1, `sel_i`=1) with `wdata_i[7]`=1 ORs `wdata_i[6:0]` into the enables. The new value is visible from the next cycle.
- R5: An enable write with `wdata_i[7]`=0 clears every enable bit written as 1 and leaves the other enable bits unchanged.
- R6: A flag write (`wr_en_i`=1, `sel_i`=0) clears every flag bit written as 1 and leaves the other flag bits unchanged. `wdata_i[7]` has no effect.
- R7: A one-cycle pulse on `t1_evt_i`, `t2_evt_i` or `sr_evt_i` sets flag bit 6, bit 5 or bit 2 respectively, in the next cycle.
- R8: When a source pulse and a flag write that clears the same bit happen in the same cycle, the bit is set.
- R9: After reset, flags, enables and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select: 0 flags, 1 enables |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| t1_evt_i | input | 1 | Timer-1 event pulse |
| t2_evt_i | input | 1 | Timer-2 event pulse |
| sr_evt_i | input | 1 | Shift-register event pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives event pulses in the same cycle as flag clears of the same bit. A design that let the clear win would lose an event and show a zero flag where the model expects a one.

Enable writes are driven in both selector modes and with bit 7 set in flag writes. Several faults would show up as a mismatched read-back value:
- a design that confused the modes;
- a design that stored bit 7;
- a design that cleared enables that were written as 0.

The summary bit and `irq_o` are compared on every cycle against a model with a one-cycle lag on the output. A design with a combinational or two-cycle output would miss by one edge.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BITS_W = DATA_W - 1;  // stored bits; top bit is the selector/summary
  localparam int unsigned T1_BIT = 6;
  localparam int unsigned T2_BIT = 5;
  localparam int unsigned SR_BIT = 2;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;  // set wins
  end

  assign flag_o = flag_q;

  // R7 R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R6
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         mode_set_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = mode_set_i ? (en_q | bits_i) : (en_q & ~bits_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  // R4 R5
  en_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q));

  // R5
  en_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((en_q & ~$past(bits_i)) == ($past(en_q) & ~$past(bits_i))));
endmodule

// File: rtl/irq_flag_enable_unit.sv
module irq_flag_enable_unit
  import irq_unit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              t1_evt_i,
  input  logic              t2_evt_i,
  input  logic              sr_evt_i,
  output logic              irq_o
);
  localparam int unsigned TOP = DATA_W - 1;

  logic [BITS_W-1:0] set_vec, clr_vec, flags, enables;
  logic              pending, irq_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(sel_i);

  always_comb begin
    set_vec         = '0;
    set_vec[T1_BIT] = t1_evt_i;
    set_vec[T2_BIT] = t2_evt_i;
    set_vec[SR_BIT] = sr_evt_i;
  end

  assign clr_vec = (wr_en_i && sel == SEL_FLAG) ? wdata_i[BITS_W-1:0] : '0;

  irq_flag_reg #(.W(BITS_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flags)
  );

  irq_enable_reg #(.W(BITS_W)) u_enables (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i && sel == SEL_EN),
    .mode_set_i (wdata_i[TOP]),
    .bits_i     (wdata_i[BITS_W-1:0]),
    .en_o       (enables)
  );

  assign pending = |(flags & enables);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pending;
  end
  assign irq_o = irq_q;

  always_comb begin
    if (sel == SEL_EN) rdata_o = {1'b1, enables};
    else               rdata_o = {pending, flags};
  end

  // R1
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(flags & enables)));

  // R3
  en_read_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 1'b1) |-> rdata_o[TOP]);
endmodule

// File: tb/irq_flag_enable_unit_tb_top.sv
module irq_flag_enable_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       t1_evt_i = 1'b0, t2_evt_i = 1'b0, sr_evt_i = 1'b0;
  logic       irq_o;

  int n_chk = 0, n_fail = 0;
  int mf = 0, me = 0;
  bit mirq = 0;

  always #5 clk_i = ~clk_i;

  irq_flag_enable_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .t1_evt_i(t1_evt_i),
    .t2_evt_i(t2_evt_i), .sr_evt_i(sr_evt_i), .irq_o(irq_o)
  );

  // reference model
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mf = 0; me = 0; mirq = 0;
    end else begin
      int setv, w;
      bit pend;
      pend = (mf & me) != 0;
      setv = (t1_evt_i ? 'h40 : 0) | (t2_evt_i ? 'h20 : 0) | (sr_evt_i ? 'h04 : 0);
      w = int'(wdata_i) & 'h7f;
      if (wr_en_i && !sel_i) mf = (mf & ~w & 'h7f) | setv;
      else                   mf = mf | setv;
      if (wr_en_i && sel_i) me = wdata_i[7] ? (me | w) : (me & ~w & 'h7f);
      mirq = pend;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(bit s);
    if (s) return me | 'h80;
    return mf | (((mf & me) != 0) ? 'h80 : 0);
  endfunction

  task automatic step(string tag, bit s, bit wr, logic [7:0] wd, bit a, bit b, bit c);
    @(negedge clk_i);
    sel_i = s; wr_en_i = wr; wdata_i = wd;
    t1_evt_i = a; t2_evt_i = b; sr_evt_i = c;
    #1;
    check({tag, (s ? " R3 rdata" : " R2 rdata")}, int'(rdata_o), exp_rd(s));
    check({tag, " R1 irq"}, int'(irq_o), int'(mirq));
  endtask

  task automatic peek(string tag, bit s, int exp);
    step(tag, s, 0, 8'h00, 0, 0, 0);
    check(tag, int'(rdata_o), exp);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #22;
    // R9 reset state
    check("R9 irq", int'(irq_o), 0);
    sel_i = 1'b0; #1 check("R9 flags", int'(rdata_o), 'h00);
    sel_i = 1'b1; #1 check("R9 enables", int'(rdata_o), 'h80);
    rst_ni = 1'b1;

    // R7 each source sets its own bit
    step("R7", 0, 0, 8'h00, 1, 0, 0);
    peek("R7 t1 bit6", 0, 'h40);
    step("R7", 0, 0, 8'h00, 0, 1, 0);
    step("R7", 0, 0, 8'h00, 0, 0, 1);
    peek("R7 all", 0, 'h64);

    // R4 set mode
    step("R4", 1, 1, 8'hC0, 0, 0, 0);
    peek("R4 en", 1, 'hC0);
    peek("R2 summary", 0, 'hE4);
    check("R1 irq high", int'(irq_o), 1);
    step("R4", 1, 1, 8'h84, 0, 0, 0);
    peek("R4 or", 1, 'hC4);

    // R5 clear mode leaves others
    step("R5", 1, 1, 8'h40, 0, 0, 0);
    peek("R5 en", 1, 'h84);

    // R6 flag clear, bit 7 ignored
    step("R6", 0, 1, 8'h80, 0, 0, 0);
    peek("R6 bit7 no effect", 0, 'hE4);
    step("R6", 0, 1, 8'h04, 0, 0, 0);
    peek("R6 clr", 0, 'h60);
    step("R1", 0, 0, 8'h00, 0, 0, 0);
    check("R1 irq low", int'(irq_o), 0);

    // R8 set beats clear
    step("R8", 0, 1, 8'h7F, 0, 0, 1);
    peek("R8 set wins", 0, 'h84);

    // mixed stimulus vs model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      step("RND", 1'($urandom), ($urandom % 3) == 0, w,
           ($urandom % 5) == 0, ($urandom % 7) == 0, ($urandom % 6) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule